// File: doc/BRIEF.md
# Configurable Per-Pin Interrupt Detector

This block turns a set of already-synchronized input lines into interrupt requests. Each line has four configuration bits. A sense bit chooses between level and edge detection. A polarity bit chooses high or rising against low or falling. A dual-edge bit makes an edge-mode line fire on either transition. An enable bit masks the line.

Edge events are caught by comparing each line with its sample from the previous cycle. A caught edge stays latched until software writes a one to that line's bit in a write-only clear register. Level conditions are not latched: the raw status of a level-mode line follows the line while the level is present.

The block presents the raw status vector and the masked status vector (one interrupt signal per line). It also drives a single combined request, which is the OR of the masked bits. Configuration arrives over a simple write-only register bus: a write strobe, an address and a data word. Each data bit maps to one line.

Top module: `pin_irq_detector`

## Requirements
- R1: After a synchronous active-low reset, every configuration bit, every raw and masked status bit and the combined request are 0. The reset defaults are therefore edge mode, falling polarity, single edge and all lines masked.
- R2: In edge mode (sense 0) with the dual-edge bit at 0, a polarity bit of 1 latches rising edges and 0 latches falling edges. A latched bit stays 1 after the line returns to its old value.
- R3: In edge mode with the dual-edge bit at 1, both rising and falling edges latch, whatever the polarity bit is.
- R4: In level mode (sense 1), the raw bit is 1 exactly while the line equals its polarity bit. It follows the line in the same cycle and is not held once the level goes away.
- R5: Each masked status bit equals the raw bit ANDed with the line's enable bit.
- R6: The combined request is 1 exactly when any masked status bit is 1.
- R7: A write of 1 to a bit of the clear register removes that line's latched edge from the next cycle on. A written 0 leaves the bit unchanged. A clear has no effect on a level-mode line.
- R8: If a qualifying edge on a line arrives in the same cycle as a clear write for that line, the raw bit stays 1.
- R9: Address map on the 3-bit bus address: 0 sense, 1 dual-edge, 2 polarity, 3 enable, 4 clear. Writes to other addresses change nothing. An edge is a difference between the current sample and the previous cycle's sample, so a line held steady never latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NUM_PINS | Synchronized input lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NUM_PINS | Write data, one bit per line |
| raw_status | output | NUM_PINS | Detected conditions before masking |
| masked_status | output | NUM_PINS | Per-line interrupt after masking |
| irq_any | output | 1 | Combined interrupt request |

## Verification
The bench aims at the cycle where a fresh edge and a clear write for the same line meet. A design that gave priority to the clear would lose that event and show 0 where 1 is expected. It checks that a latched edge survives the line returning to its idle value; a design that failed to latch would drop the bit. It drives the dual-edge bit against an opposing polarity bit, so a design that ignored the override would miss half the transitions. In level mode it issues clears and moves the line away, so a design that latched or cleared level status would show a stale or missing bit. It also writes an unused address, where a sloppy decoder would alter a register.

// File: rtl/pirq_pkg.sv
// Package: shared register map for the per-pin interrupt detector.
// Assumes a 3-bit word address on the configuration bus.
package pirq_pkg;
    localparam int PIRQ_ADDR_W = 3;

    typedef enum logic [PIRQ_ADDR_W-1:0] {
        REG_SENSE  = 3'd0,
        REG_DUAL   = 3'd1,
        REG_POL    = 3'd2,
        REG_ENABLE = 3'd3,
        REG_CLEAR  = 3'd4
    } pirq_reg_e;
endpackage

// File: rtl/pirq_cfg_regs.sv
// Configuration register file: holds the sense, dual-edge, polarity and
// enable vectors and turns clear-register writes into a one-cycle pulse.
// Assumes the bus writes whole words; unmapped addresses are ignored.
module pirq_cfg_regs
    import pirq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [PIRQ_ADDR_W-1:0] bus_addr,
    input  logic [NUM_PINS-1:0]    bus_wdata,
    output logic [NUM_PINS-1:0]    sense_q,
    output logic [NUM_PINS-1:0]    dual_q,
    output logic [NUM_PINS-1:0]    pol_q,
    output logic [NUM_PINS-1:0]    enable_q,
    output logic [NUM_PINS-1:0]    clr_pulse
);
    pirq_reg_e sel;
    assign sel = pirq_reg_e'(bus_addr);

    // Update the addressed configuration register on a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q  <= '0;
            dual_q   <= '0;
            pol_q    <= '0;
            enable_q <= '0;
        end else if (bus_wr) begin
            case (sel)
                REG_SENSE:  sense_q  <= bus_wdata;
                REG_DUAL:   dual_q   <= bus_wdata;
                REG_POL:    pol_q    <= bus_wdata;
                REG_ENABLE: enable_q <= bus_wdata;
                default:    ;
            endcase
        end
    end

    // Decode a clear-register write into a per-line clear strobe.
    always_comb begin
        clr_pulse = '0;
        if (bus_wr && sel == REG_CLEAR) begin
            clr_pulse = bus_wdata;
        end
    end
endmodule

// File: rtl/pirq_pin_detect.sv
// Single-line detector: keeps the previous sample, finds qualifying edges,
// latches them until cleared, and forms the raw status bit.
// Assumes pin is already synchronized to clk.
module pirq_pin_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic sense,
    input  logic dual,
    input  logic pol,
    input  logic clr,
    output logic raw,
    output logic hit,
    output logic prev
);
    logic rise;
    logic fall;
    logic edge_q;

    // Remember the line value from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= pin;
    end

    // Pick the qualifying edge from the dual-edge and polarity bits.
    always_comb begin
        rise = pin & ~prev;
        fall = ~pin & prev;
        if (sense)     hit = 1'b0;
        else if (dual) hit = rise | fall;
        else if (pol)  hit = rise;
        else           hit = fall;
    end

    // Latch edges; a new edge beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     edge_q <= 1'b0;
        else if (sense) edge_q <= 1'b0;
        else            edge_q <= (edge_q & ~clr) | hit;
    end

    // Level mode follows the line; edge mode shows the latch.
    always_comb begin
        raw = sense ? ~(pin ^ pol) : edge_q;
    end
endmodule

// File: rtl/pirq_combine.sv
// Applies the enable mask and ORs the masked bits into one request.
// Purely combinational.
module pirq_combine #(
    parameter int NUM_PINS = 8
) (
    input  logic [NUM_PINS-1:0] raw,
    input  logic [NUM_PINS-1:0] enable,
    output logic [NUM_PINS-1:0] masked,
    output logic                any
);
    // Mask each line and reduce to the combined request.
    always_comb begin
        masked = raw & enable;
        any    = |masked;
    end
endmodule

// File: rtl/pin_irq_detector.sv
// Top level: per-line interrupt detection with configurable sense, polarity
// and dual-edge modes, write-one-to-clear edge latches and an enable mask.
// Assumes pin_in is synchronous to clk and the bus is write-only.
module pin_irq_detector
    import pirq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PINS-1:0]    pin_in,
    input  logic                   bus_wr,
    input  logic [PIRQ_ADDR_W-1:0] bus_addr,
    input  logic [NUM_PINS-1:0]    bus_wdata,
    output logic [NUM_PINS-1:0]    raw_status,
    output logic [NUM_PINS-1:0]    masked_status,
    output logic                   irq_any
);
    logic [NUM_PINS-1:0] sense_q;
    logic [NUM_PINS-1:0] dual_q;
    logic [NUM_PINS-1:0] pol_q;
    logic [NUM_PINS-1:0] enable_q;
    logic [NUM_PINS-1:0] clr_pulse;
    logic [NUM_PINS-1:0] edge_hit;
    logic [NUM_PINS-1:0] pin_prev;

    pirq_cfg_regs #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .sense_q   (sense_q),
        .dual_q    (dual_q),
        .pol_q     (pol_q),
        .enable_q  (enable_q),
        .clr_pulse (clr_pulse)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pirq_pin_detect u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_in[i]),
            .sense (sense_q[i]),
            .dual  (dual_q[i]),
            .pol   (pol_q[i]),
            .clr   (clr_pulse[i]),
            .raw   (raw_status[i]),
            .hit   (edge_hit[i]),
            .prev  (pin_prev[i])
        );
    end

    pirq_combine #(.NUM_PINS(NUM_PINS)) u_comb (
        .raw    (raw_status),
        .enable (enable_q),
        .masked (masked_status),
        .any    (irq_any)
    );
endmodule

// File: rtl/pin_irq_checker.sv
// Assertion checker for pin_irq_detector, attached with bind.
// Assumes the synchronous active-low reset of the design.
module pin_irq_checker #(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] pin_in,
    input logic                bus_wr,
    input logic [NUM_PINS-1:0] raw_status,
    input logic [NUM_PINS-1:0] masked_status,
    input logic                irq_any,
    input logic [NUM_PINS-1:0] sense_q,
    input logic [NUM_PINS-1:0] clr_pulse,
    input logic [NUM_PINS-1:0] edge_hit,
    input logic [NUM_PINS-1:0] pin_prev
);
    AST_RESET_CLEAN: assert property (@(posedge clk)
        !rst_n |=> (raw_status == '0 && masked_status == '0 && !irq_any)); // R1

    AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_status & ~raw_status) == '0); // R5

    AST_ANY_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any == (masked_status != '0)); // R6

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_line
        AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (raw_status[i] && !sense_q[i] && !clr_pulse[i] && !bus_wr)
            |=> raw_status[i]); // R2

        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (!sense_q[i] && clr_pulse[i] && pin_in[i] == pin_prev[i])
            |=> !raw_status[i]); // R7

        AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_hit[i] && clr_pulse[i]) |=> raw_status[i]); // R8
    end
endmodule

bind pin_irq_detector pin_irq_checker #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pin_in        (pin_in),
    .bus_wr        (bus_wr),
    .raw_status    (raw_status),
    .masked_status (masked_status),
    .irq_any       (irq_any),
    .sense_q       (sense_q),
    .clr_pulse     (clr_pulse),
    .edge_hit      (edge_hit),
    .pin_prev      (pin_prev)
);

// File: tb/pin_irq_detector_test.sv
`timescale 1ns/1ps
module pin_irq_detector_test;
    localparam int N = 8;
    localparam logic [2:0] A_SENSE = 3'd0, A_DUAL = 3'd1, A_POL = 3'd2,
                           A_EN = 3'd3, A_CLR = 3'd4, A_UNUSED = 3'd5;

    typedef struct packed {
        logic [7:0] sense, dual, pol, en, start, nxt, raw, msk;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h0F, 8'h0F, 8'h0F}, // R2 rising
        '{8'h00, 8'h00, 8'h00, 8'h0F, 8'hFF, 8'h33, 8'hCC, 8'h0C}, // R2 falling, R5
        '{8'h00, 8'hFF, 8'h00, 8'hFF, 8'h0F, 8'hF0, 8'hFF, 8'hFF}, // R3 dual edge
        '{8'hFF, 8'h00, 8'hAA, 8'hF0, 8'h00, 8'hA5, 8'hF0, 8'hF0}, // R4 level
        '{8'h0F, 8'hC0, 8'h33, 8'hFF, 8'h00, 8'h5A, 8'h56, 8'h56}, // R2 R3 R4 mixed
        '{8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00}  // R5 R6 masked
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_in = '0;
    logic         bus_wr = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] raw_status;
    logic [N-1:0] masked_status;
    logic         irq_any;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pin_irq_detector #(.NUM_PINS(N)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_in        (pin_in),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .raw_status    (raw_status),
        .masked_status (masked_status),
        .irq_any       (irq_any)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(string req, logic [7:0] er, logic [7:0] em);
        check({req, " raw"}, raw_status, er);
        check({req, " masked"}, masked_status, em);
        check({req, " any"}, {7'd0, irq_any}, {7'd0, |em});
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic step_pin(logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset", 8'h00, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk.
        for (int k = 0; k < NV; k++) begin
            step_pin(VECS[k].start);
            wr(A_SENSE, VECS[k].sense);
            wr(A_DUAL, VECS[k].dual);
            wr(A_POL, VECS[k].pol);
            wr(A_EN, VECS[k].en);
            wr(A_CLR, 8'hFF);
            step_pin(VECS[k].nxt);
            check_all($sformatf("R2/R3/R4/R5/R6 vector %0d", k), VECS[k].raw, VECS[k].msk);
        end

        // R9: steady line never latches; R2: latch survives return.
        wr(A_SENSE, 8'h00); wr(A_DUAL, 8'h00); wr(A_POL, 8'hFF); wr(A_EN, 8'hFF);
        step_pin(8'h00);
        wr(A_CLR, 8'hFF);
        step_pin(8'h00);
        check("R9 steady line", raw_status, 8'h00);
        step_pin(8'h0F);
        step_pin(8'h00);
        check("R2 latch held", raw_status, 8'h0F);

        // R7: ones clear, zeros ignored.
        wr(A_CLR, 8'h05);
        check("R7 partial clear", raw_status, 8'h0A);
        wr(A_CLR, 8'h00);
        check("R7 zero write", raw_status, 8'h0A);

        // R8: new edge in the clear cycle wins.
        wr(A_CLR, 8'hFF);
        step_pin(8'h01);
        check("R8 setup", raw_status, 8'h01);
        @(negedge clk);
        pin_in = 8'h03; bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 8'h03;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R8 edge beats clear", raw_status, 8'h02);

        // R4/R7: level mode follows the line and ignores clears.
        wr(A_POL, 8'h0F);
        wr(A_SENSE, 8'hFF);
        check("R4 level match", raw_status, 8'hF3);
        wr(A_CLR, 8'hFF);
        check("R7 clear ignored in level", raw_status, 8'hF3);
        @(negedge clk);
        pin_in = 8'h0F;
        #1;
        check("R4 follows line", raw_status, 8'hFF);
        @(negedge clk);
        pin_in = 8'hF0;
        #1;
        check("R4 not held", raw_status, 8'h00);

        // R5/R6: enable mask.
        @(negedge clk);
        pin_in = 8'h0F;
        wr(A_EN, 8'h00);
        check_all("R5 all masked", 8'hFF, 8'h00);
        wr(A_EN, 8'h81);
        check_all("R6 two enabled", 8'hFF, 8'h81);

        // R9: unmapped address changes nothing.
        wr(A_UNUSED, 8'h00);
        check_all("R9 unused address", 8'hFF, 8'h81);

        // R1: reset restores defaults (edge, falling, masked).
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_all("R1 after reset", 8'h00, 8'h00);
        step_pin(8'h0F);
        step_pin(8'h00);
        check_all("R1 default falling masked", 8'h0F, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule